// File: doc/BRIEF.md
# Justified-Format Audio Serial Receiver

This block receives a two-channel serial audio stream made of a bit clock, a word-select line and a data line, and turns it into 16-bit words for a host to read. The transmitter changes word select and data on the falling bit-clock edge. The receiver captures them on the rising edge, which it detects by sampling the bit clock in the system clock domain. A change of word select marks the first bit of a new channel. The left channel (word select low) comes first in a frame and the right channel (word select high) follows.

The sample can sit at the start of its channel (MSB-justified) or at the end (LSB-justified). The bits around it are padding, and the receiver drops them whatever their value. A 16-bit sample is delivered as one word. A 24-bit sample is delivered as two words: the upper byte first, zero-extended, then the lower sixteen bits. Each word carries a tag giving the channel it came from.

After enable rises, the receiver waits for the first change of word select before it delivers anything, so it never hands over a partial first channel.

Top module: `justified_audio_rx`

## Requirements
- R1: While reset is high, and on the first cycle after it, `rx_avail`, `rx_overrun`, `rx_right` and `rd_data` are all 0.
- R2: After `en` rises, no bit is used until word select has changed value between two rising bit-clock edges. The bit where that change is seen is bit 0 of a channel. Bits sent while word select stays constant are never delivered.
- R3: With `fmt_lsb` = 0 (MSB-justified), the sample is the first data-length bits of the channel, most significant bit first, and the remaining bits are ignored.
- R4: With `fmt_lsb` = 1 (LSB-justified), the sample is the last data-length bits of the channel, most significant bit first, and the leading bits are ignored.
- R5: When the channel length equals the data length, both settings of `fmt_lsb` deliver the same words from the same serial stream.
- R6: `dlen_code` 2'b01 selects 24-bit data; every other code selects 16-bit data. `chan32` = 1 selects a 32-bit channel and 0 selects a 16-bit channel. 24-bit data always uses a 32-bit channel.
- R7: A 16-bit sample D is delivered as one word equal to D[15:0].
- R8: A 24-bit sample D is delivered as two words in order: {8'h00, D[23:16]} and then D[15:0].
- R9: `rx_right` is 0 while the available word came from the left channel (word select low) and 1 while it came from the right channel (word select high).
- R10: `rx_avail` rises in the cycle after the last bit of a sample is captured. A cycle with `rd_en` high while a word is available consumes that word. When the last word has been consumed, `rx_avail` falls.
- R11: If a sample completes while an earlier word has not been consumed, `rx_overrun` goes to 1 and stays 1 while `en` is high. The new sample replaces the unread words.
- R12: A cycle with `en` low clears `rx_avail`, `rx_overrun` and any pending word, and the receiver must find a new word-select change before it delivers again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Receiver enable |
| fmt_lsb | input | 1 | 0 = MSB-justified, 1 = LSB-justified |
| dlen_code | input | 2 | Data length: 2'b01 = 24 bits, otherwise 16 bits |
| chan32 | input | 1 | Channel length: 1 = 32 bits, 0 = 16 bits |
| sck | input | 1 | Serial bit clock, sampled by `clk` |
| ws | input | 1 | Word select: 0 = left, 1 = right |
| sd | input | 1 | Serial data |
| rd_en | input | 1 | Consume the available word |
| rd_data | output | 16 | Available word |
| rx_avail | output | 1 | A word is available |
| rx_overrun | output | 1 | A sample was lost |
| rx_right | output | 1 | Channel of the available word |

## Verification
The bench fills the padding with a non-zero pattern. A receiver that took the wrong end of the channel, or kept padding bits, would return visibly wrong words. Each stream starts with a few bits of a partial channel. A receiver that did not wait for the first word-select change would deliver junk, or shift the left sample. A 24-bit sample sent in a nominal 16-bit channel checks that the 32-bit channel is forced. If the forcing were missing, the sample would be truncated. Two samples completing without a read must raise the overrun flag and leave the newer word. Dropping enable must clear the flags. Leaving them set would show up as stale data in the next stream.

// File: rtl/jrx_pkg.sv
package jrx_pkg;

    localparam int unsigned WORD_W   = 16;
    localparam int unsigned SAMPLE_W = 24;
    localparam int unsigned CNT_W    = 6;
    localparam int unsigned HIGH_W   = SAMPLE_W - WORD_W;

    localparam logic [1:0] DLEN_WIDE = 2'b01;

    typedef struct packed {
        logic [SAMPLE_W-1:0] data;
        logic                right;
        logic                wide;
    } sample_t;

    // number of sample bits for a data-length code
    function automatic logic [CNT_W-1:0] data_bits(input logic [1:0] code);
        return (code == DLEN_WIDE) ? CNT_W'(24) : CNT_W'(16);
    endfunction

    // number of bits in a channel; wide samples always need 32
    function automatic logic [CNT_W-1:0] chan_bits(input logic [1:0] code,
                                                  input logic       ch32);
        return (ch32 || code == DLEN_WIDE) ? CNT_W'(32) : CNT_W'(16);
    endfunction

endpackage

// File: rtl/jrx_front.sv
module jrx_front (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic sck,
    input  logic ws,
    input  logic sd,
    output logic bit_stb,
    output logic bit_first,
    output logic bit_val,
    output logic bit_ws
);
    logic sck_q;
    logic ws_last_q;
    logic ws_seen_q;
    logic locked_q;
    logic rise;
    logic ws_edge;

    always_comb begin
        rise      = sck && !sck_q && en;
        ws_edge   = ws_seen_q && (ws != ws_last_q);
        bit_first = rise && ws_edge;
        bit_stb   = rise && (locked_q || ws_edge);
        bit_val   = sd;
        bit_ws    = ws;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q     <= 1'b0;
            ws_last_q <= 1'b0;
            ws_seen_q <= 1'b0;
            locked_q  <= 1'b0;
        end else begin
            sck_q <= sck;
            if (!en) begin
                ws_seen_q <= 1'b0;
                locked_q  <= 1'b0;
            end else if (rise) begin
                ws_last_q <= ws;
                ws_seen_q <= 1'b1;
                if (ws_edge) locked_q <= 1'b1;
            end
        end
    end

    // lock only follows an observed word-select change
    assert_lock_after_edge_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_q) |-> $past(bit_first));

endmodule

// File: rtl/jrx_extract.sv
module jrx_extract
    import jrx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       fmt_lsb,
    input  logic [1:0] dlen_code,
    input  logic       chan32,
    input  logic       bit_stb,
    input  logic       bit_first,
    input  logic       bit_val,
    input  logic       bit_ws,
    output logic       done,
    output sample_t    samp
);
    logic [CNT_W-1:0]    cnt_q;
    logic [CNT_W-1:0]    idx, db, cb, lo, hi, last_idx;
    logic                in_window;
    logic [SAMPLE_W-2:0] shift_q;
    logic [SAMPLE_W-1:0] next_shift;

    always_comb begin
        db         = data_bits(dlen_code);
        cb         = chan_bits(dlen_code, chan32);
        idx        = bit_first ? '0 : cnt_q;
        lo         = fmt_lsb ? (cb - db) : '0;
        hi         = fmt_lsb ? cb : db;
        last_idx   = hi - CNT_W'(1);
        in_window  = (idx >= lo) && (idx < hi);
        done       = bit_stb && in_window && (idx == last_idx);
        next_shift = {shift_q, bit_val};
        samp.wide  = (db == CNT_W'(SAMPLE_W));
        samp.right = bit_ws;
        samp.data  = samp.wide ? next_shift
                               : {{HIGH_W{1'b0}}, next_shift[WORD_W-1:0]};
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q   <= '0;
            shift_q <= '0;
        end else if (bit_stb) begin
            cnt_q <= (idx == '1) ? idx : idx + CNT_W'(1);
            if (in_window) shift_q <= next_shift[SAMPLE_W-2:0];
        end
    end

    // the counter restarts at a channel start
    assert_restart_on_edge_R2: assert property (@(posedge clk) disable iff (rst)
        bit_stb && bit_first && en |=> cnt_q == CNT_W'(1));

endmodule

// File: rtl/jrx_rdport.sv
module jrx_rdport
    import jrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              done,
    input  sample_t           samp,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              avail,
    output logic              ovr,
    output logic              right
);
    logic [WORD_W-1:0] data_q, pend_q;
    logic              avail_q, pend_v_q, ovr_q, right_q;
    logic              lost;

    always_comb begin
        lost    = pend_v_q || (avail_q && !rd_en);
        rd_data = data_q;
        avail   = avail_q;
        ovr     = ovr_q;
        right   = right_q;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            data_q   <= '0;
            pend_q   <= '0;
            avail_q  <= 1'b0;
            pend_v_q <= 1'b0;
            ovr_q    <= 1'b0;
            right_q  <= 1'b0;
        end else if (done) begin
            data_q   <= samp.wide ? {{(WORD_W-HIGH_W){1'b0}}, samp.data[SAMPLE_W-1:WORD_W]}
                                  : samp.data[WORD_W-1:0];
            pend_q   <= samp.data[WORD_W-1:0];
            pend_v_q <= samp.wide;
            avail_q  <= 1'b1;
            right_q  <= samp.right;
            if (lost) ovr_q <= 1'b1;
        end else if (rd_en && avail_q) begin
            if (pend_v_q) begin
                data_q   <= pend_q;
                pend_v_q <= 1'b0;
            end else begin
                avail_q <= 1'b0;
            end
        end
    end

    assert_fill_sets_avail_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> avail);

    assert_drain_clears_R10: assert property (@(posedge clk) disable iff (rst)
        rd_en && avail && !pend_v_q && !done && en |=> !avail);

    assert_high_word_zero_R8: assert property (@(posedge clk) disable iff (rst)
        done && samp.wide |=> rd_data[WORD_W-1:HIGH_W] == '0);

    assert_overrun_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        ovr && en |=> ovr);

    assert_disable_clears_R12: assert property (@(posedge clk) disable iff (rst)
        !en |=> !avail && !ovr);

    assert_side_tag_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> right == $past(samp.right));

endmodule

// File: rtl/justified_audio_rx.sv
module justified_audio_rx
    import jrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              fmt_lsb,
    input  logic [1:0]        dlen_code,
    input  logic              chan32,
    input  logic              sck,
    input  logic              ws,
    input  logic              sd,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              rx_avail,
    output logic              rx_overrun,
    output logic              rx_right
);
    logic    bit_stb, bit_first, bit_val, bit_ws;
    logic    done;
    sample_t samp;

    jrx_front u_front (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .sck       (sck),
        .ws        (ws),
        .sd        (sd),
        .bit_stb   (bit_stb),
        .bit_first (bit_first),
        .bit_val   (bit_val),
        .bit_ws    (bit_ws)
    );

    jrx_extract u_extract (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .fmt_lsb   (fmt_lsb),
        .dlen_code (dlen_code),
        .chan32    (chan32),
        .bit_stb   (bit_stb),
        .bit_first (bit_first),
        .bit_val   (bit_val),
        .bit_ws    (bit_ws),
        .done      (done),
        .samp      (samp)
    );

    jrx_rdport u_rdport (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .done    (done),
        .samp    (samp),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .avail   (rx_avail),
        .ovr     (rx_overrun),
        .right   (rx_right)
    );

endmodule

// File: tb/justified_audio_rx_tb.sv
module justified_audio_rx_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        fmt_lsb = 1'b0;
    logic [1:0]  dlen_code = 2'b00;
    logic        chan32 = 1'b0;
    logic        sck = 1'b0;
    logic        ws = 1'b1;
    logic        sd = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        rx_avail, rx_overrun, rx_right;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [63:0] PAD = 64'h0000_0000_A5C3_96F1;

    // {fmt_lsb, dlen_code, chan32, left[23:0], right[23:0]}
    localparam int NVEC = 7;
    localparam logic [51:0] VEC [NVEC] = '{
        {1'b0, 2'b00, 1'b0, 24'h00_B3C1, 24'h00_4E27},
        {1'b1, 2'b00, 1'b0, 24'h00_B3C1, 24'h00_4E27},
        {1'b0, 2'b00, 1'b1, 24'h00_9A5F, 24'h00_1234},
        {1'b1, 2'b00, 1'b1, 24'h00_C0DE, 24'h00_7F81},
        {1'b0, 2'b01, 1'b1, 24'hD2_6B19, 24'h3C_E807},
        {1'b1, 2'b01, 1'b1, 24'hA1_5F3E, 24'h6E_0D92},
        {1'b1, 2'b01, 1'b0, 24'h81_2345, 24'h5A_A55A}
    };

    justified_audio_rx u_dut (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .fmt_lsb    (fmt_lsb),
        .dlen_code  (dlen_code),
        .chan32     (chan32),
        .sck        (sck),
        .ws         (ws),
        .sd         (sd),
        .rd_en      (rd_en),
        .rd_data    (rd_data),
        .rx_avail   (rx_avail),
        .rx_overrun (rx_overrun),
        .rx_right   (rx_right)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic send_bit(input logic w, input logic d);
        @(negedge clk);
        sck = 1'b0; ws = w; sd = d;
        repeat (2) @(negedge clk);
        sck = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [31:0] chan_word(input logic lsb, input int db,
                                              input int cb, input logic [23:0] d);
        logic [63:0] dm, w;
        dm = {40'b0, d} & ((64'd1 << db) - 64'd1);
        if (!lsb) w = (dm << (cb - db)) | (PAD & ((64'd1 << (cb - db)) - 64'd1));
        else      w = ((PAD << db) | dm) & ((64'd1 << cb) - 64'd1);
        return w[31:0];
    endfunction

    task automatic send_chan(input logic w, input logic [31:0] word, input int cb);
        for (int i = cb - 1; i >= 0; i--) send_bit(w, word[i]);
    endtask

    task automatic pop();
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic read_sample(input string tag, input logic wide,
                               input logic [23:0] d, input logic side);
        chk(tag, "avail", {15'b0, rx_avail}, 16'd1);
        chk("R9", "side", {15'b0, rx_right}, {15'b0, side});
        if (wide) begin
            chk({tag, " R8"}, "high word", rd_data, {8'h00, d[23:16]});
            pop();
            chk("R10", "avail mid", {15'b0, rx_avail}, 16'd1);
            chk({tag, " R8"}, "low word", rd_data, d[15:0]);
        end else begin
            chk({tag, " R7"}, "word", rd_data, d[15:0]);
        end
        pop();
        chk("R10", "drained", {15'b0, rx_avail}, 16'd0);
    endtask

    task automatic run_vec(input logic [51:0] v);
        int db, cb;
        string tag;
        en = 1'b0;
        repeat (2) @(negedge clk);
        fmt_lsb = v[51]; dlen_code = v[50:49]; chan32 = v[48];
        db = (v[50:49] == 2'b01) ? 24 : 16;
        cb = (v[48] || v[50:49] == 2'b01) ? 32 : 16;
        if (db == cb)                        tag = "R5";
        else if (v[50:49] == 2'b01 && !v[48]) tag = "R6";
        else if (v[51])                      tag = "R4";
        else                                 tag = "R3";
        en = 1'b1;
        // partial right channel before the first word-select change
        for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b1);
        chk("R2", "no data before sync", {15'b0, rx_avail}, 16'd0);
        send_chan(1'b0, chan_word(v[51], db, cb, v[47:24]), cb);
        read_sample(tag, db == 24, v[47:24], 1'b0);
        send_chan(1'b1, chan_word(v[51], db, cb, v[23:0]), cb);
        read_sample(tag, db == 24, v[23:0], 1'b1);
        en = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all requirements actual=hung expected=complete");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "avail", {15'b0, rx_avail}, 16'd0);
        chk("R1", "overrun", {15'b0, rx_overrun}, 16'd0);
        chk("R1", "data", rd_data, 16'h0000);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "side", {15'b0, rx_right}, 16'd0);

        for (int k = 0; k < NVEC; k++) run_vec(VEC[k]);

        // R2: constant word select never produces data
        fmt_lsb = 1'b0; dlen_code = 2'b00; chan32 = 1'b0;
        en = 1'b1;
        for (int i = 0; i < 40; i++) send_bit(1'b0, i[0]);
        chk("R2", "no edge no data", {15'b0, rx_avail}, 16'd0);
        en = 1'b0;
        @(negedge clk);

        // R11: two samples without a read
        en = 1'b1;
        send_bit(1'b1, 1'b0);
        send_chan(1'b0, 32'h0000_1111, 16);
        send_chan(1'b1, 32'h0000_2222, 16);
        chk("R11", "overrun set", {15'b0, rx_overrun}, 16'd1);
        chk("R11", "newest kept", rd_data, 16'h2222);
        chk("R11 R9", "newest side", {15'b0, rx_right}, 16'd1);
        pop();
        chk("R11", "overrun sticky", {15'b0, rx_overrun}, 16'd1);

        // R12: disable clears and forces resync
        en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R12", "overrun cleared", {15'b0, rx_overrun}, 16'd0);
        chk("R12", "avail cleared", {15'b0, rx_avail}, 16'd0);
        en = 1'b1;
        for (int i = 0; i < 20; i++) send_bit(1'b1, 1'b1);
        chk("R12", "resync wait", {15'b0, rx_avail}, 16'd0);
        en = 1'b0;
        repeat (2) @(negedge clk);

        finish_run();
    end

endmodule